// File: doc/BRIEF.md
# Compound Horizontal Diffusion Stencil Engine

This block holds one 3-D tile of signed fixed-point samples in on-chip plane banks and applies a compound horizontal diffusion operator to it. For each interior point it first forms a 5-point Laplacian at the point and at its four horizontal neighbours. It then takes row and column flux differences of those Laplacians and subtracts a scaled version of their sum from the source sample. Planes along the depth axis do not depend on each other. The result is one output sample per interior point, streamed in raster order.

Software, or an upstream loader, fills the tile through a write port while the engine is idle. It loads a signed coefficient and pulses `start`. The engine then steps through every interior point and issues one result per clock while the consumer keeps `out_ready` high. It marks the final sample of the tile and pulses `done` once that sample is taken. A small state machine sequences the run. `ST_IDLE` goes to `ST_RUN` on an accepted `start`. `ST_RUN` goes to `ST_DRAIN` when the final point is loaded into the output register. `ST_DRAIN` goes to `ST_FINISH` when that final sample is handed over. `ST_FINISH` returns to `ST_IDLE` after one cycle, and `done` is high for that cycle.

Top module: `hdiff_stencil_top`

## Requirements
- R1: While `busy` is low, a cycle with `fill_en` high stores `fill_data` at plane `fill_plane`, column `fill_col`, row `fill_row`. Fill writes made while `busy` is high are discarded and do not change any later result.
- R2: A cycle with `coef_we` high loads `coef_in`, a signed value with FRAC fraction bits, into the coefficient register. A run uses the value the register holds when `start` is accepted, or `coef_in` if `coef_we` is high in that same cycle. Coefficient writes made during a run apply only to later runs.
- R3: Results come out with plane as the outer loop, column as the middle loop and row as the inner loop. Only points with column in [2, COLS-3] and row in [2, ROWS-3] are produced, so one run gives exactly DEPTH·(COLS-4)·(ROWS-4) samples.
- R4: With L(c,r) = 4·s(c,r) − s(c−1,r) − s(c+1,r) − s(c,r−1) − s(c,r+1), the flux sum is F = (L(c+1,r) − L(c,r)) − (L(c,r) − L(c−1,r)) + (L(c,r+1) − L(c,r)) − (L(c,r) − L(c,r−1)). The output is s(c,r) − k·F, where k is the coefficient.
- R5: The product k·F is rounded by adding 2^(FRAC−1) and then shifting arithmetically right by FRAC bits (round half toward plus infinity). Intermediate sums are wide enough that they never wrap.
- R6: If the final difference falls outside the signed DW-bit range, it saturates to the largest positive or most negative DW-bit value.
- R7: `out_last` is high on the last sample of the tile and low on every other sample.
- R8: Once `out_valid` is high, it stays high with `out_data` and `out_last` unchanged until `out_ready` is high. With `out_ready` held high, consecutive samples arrive on consecutive cycles.
- R9: `busy` is high from the cycle after `start` is accepted until `done`. `done` is a one-cycle pulse in the cycle after the last sample is accepted.
- R10: A `start` pulse while `busy` is high is ignored. The run in progress keeps its sequence and its sample count.
- R11: After reset, `busy`, `done` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Tile write strobe |
| fill_plane | input | idx_w(DEPTH) | Plane index of the write |
| fill_col | input | idx_w(COLS) | Column index of the write |
| fill_row | input | idx_w(ROWS) | Row index of the write |
| fill_data | input | DW | Signed sample to store |
| coef_we | input | 1 | Coefficient register write strobe |
| coef_in | input | KW | Signed coefficient, FRAC fraction bits |
| start | input | 1 | Begin a run over the stored tile |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| out_valid | output | 1 | Result sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_data | output | DW | Signed result sample |
| out_last | output | 1 | Marks the final sample of the tile |

## Verification
The coefficient register can be written in the same cycle that `start` is accepted. The test drives `coef_we` together with the `start` pulse and checks every result of that run against the newly written value, not the one held before. The same run also writes the coefficient, writes a tile sample and repeats `start` while it is busy. A follow-up run with no new writes must then show the mid-run coefficient in use, the tile unchanged, and a correct sample count in both runs.

// File: rtl/hdiff_pkg.sv
package hdiff_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } hd_state_t;

    // taps 0..4 are the five Laplacian centres: (0,0) (0,-1) (0,+1) (-1,0) (+1,0)
    localparam int NTAPS = 13;
    localparam int NLAPS = 5;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // column offset of tap k
    function automatic int tap_dc(input int k);
        case (k)
            3, 9, 10:  return -1;
            4, 11, 12: return 1;
            7:         return -2;
            8:         return 2;
            default:   return 0;
        endcase
    endfunction

    // row offset of tap k
    function automatic int tap_dr(input int k);
        case (k)
            1, 9, 11:  return -1;
            2, 10, 12: return 1;
            5:         return -2;
            6:         return 2;
            default:   return 0;
        endcase
    endfunction

    // j-th horizontal neighbour (tap index) of Laplacian centre k
    function automatic int lap_nb(input int k, input int j);
        case (k * 4 + j)
            0: return 1;   1: return 2;   2: return 3;   3: return 4;
            4: return 5;   5: return 0;   6: return 9;   7: return 11;
            8: return 0;   9: return 6;  10: return 10; 11: return 12;
           12: return 9;  13: return 10; 14: return 7;  15: return 0;
           16: return 11; 17: return 12; 18: return 0;  19: return 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/hdiff_plane_store.sv
module hdiff_plane_store
    import hdiff_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int COLS  = 8,
    parameter int ROWS  = 7,
    parameter int DW    = 16
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [idx_w(DEPTH)-1:0]   wr_plane,
    input  logic [idx_w(COLS)-1:0]    wr_col,
    input  logic [idx_w(ROWS)-1:0]    wr_row,
    input  logic [DW-1:0]             wr_data,
    input  logic [idx_w(DEPTH)-1:0]   rd_plane,
    input  logic [idx_w(COLS)-1:0]    rd_col,
    input  logic [idx_w(ROWS)-1:0]    rd_row,
    output logic [NTAPS*DW-1:0]       taps
);

    localparam int PLANE_WORDS = COLS * ROWS;
    localparam int AW          = idx_w(PLANE_WORDS);

    logic [NTAPS*DW-1:0] bank_taps [DEPTH];

    // one bank per depth plane; every bank serves all taps of the stencil
    for (genvar p = 0; p < DEPTH; p++) begin : g_bank
        logic [DW-1:0] mem [PLANE_WORDS];
        logic [AW-1:0] wa;
        logic          wr_hit;

        always_comb begin
            wa     = AW'(int'(wr_col) * ROWS + int'(wr_row));
            wr_hit = wr_en && (int'(wr_plane) == p)
                     && (int'(wr_col) < COLS) && (int'(wr_row) < ROWS);
        end

        always_ff @(posedge clk) begin
            if (wr_hit) begin
                mem[wa] <= wr_data;
            end
        end

        always_comb begin
            int ci;
            int ri;
            logic [AW-1:0] ra;
            bank_taps[p] = '0;
            for (int t = 0; t < NTAPS; t++) begin
                ci = int'(rd_col) + tap_dc(t);
                ri = int'(rd_row) + tap_dr(t);
                ra = AW'(ci * ROWS + ri);
                if (ci >= 0 && ci < COLS && ri >= 0 && ri < ROWS) begin
                    bank_taps[p][t*DW +: DW] = mem[ra];
                end
            end
        end
    end

    always_comb begin
        taps = bank_taps[0];
        for (int p = 1; p < DEPTH; p++) begin
            if (int'(rd_plane) == p) begin
                taps = bank_taps[p];
            end
        end
    end

endmodule

// File: rtl/hdiff_scan.sv
module hdiff_scan
    import hdiff_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int COLS  = 8,
    parameter int ROWS  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    advance,
    output logic [idx_w(DEPTH)-1:0] d_idx,
    output logic [idx_w(COLS)-1:0]  c_idx,
    output logic [idx_w(ROWS)-1:0]  r_idx,
    output logic                    at_end
);

    localparam int DWI  = idx_w(DEPTH);
    localparam int CWI  = idx_w(COLS);
    localparam int RWI  = idx_w(ROWS);
    localparam int C_HI = COLS - 3;
    localparam int R_HI = ROWS - 3;

    logic r_wrap;
    logic c_wrap;
    logic d_wrap;

    always_comb begin
        r_wrap = (r_idx == RWI'(R_HI));
        c_wrap = (c_idx == CWI'(C_HI));
        d_wrap = (d_idx == DWI'(DEPTH - 1));
        at_end = r_wrap && c_wrap && d_wrap;
    end

    // row is the fastest index, plane the slowest
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_idx <= '0;
            c_idx <= CWI'(2);
            r_idx <= RWI'(2);
        end else if (clear) begin
            d_idx <= '0;
            c_idx <= CWI'(2);
            r_idx <= RWI'(2);
        end else if (advance) begin
            if (r_wrap) begin
                r_idx <= RWI'(2);
                if (c_wrap) begin
                    c_idx <= CWI'(2);
                    d_idx <= d_wrap ? '0 : d_idx + 1'b1;
                end else begin
                    c_idx <= c_idx + 1'b1;
                end
            end else begin
                r_idx <= r_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hdiff_diff_core.sv
module hdiff_diff_core
    import hdiff_pkg::*;
#(
    parameter int DW   = 16,
    parameter int KW   = 16,
    parameter int FRAC = 8
) (
    input  logic [NTAPS*DW-1:0]   taps,
    input  logic signed [KW-1:0]  coef,
    output logic [DW-1:0]         result
);

    localparam int LW = DW + 4;   // one Laplacian
    localparam int SW = LW + 4;   // flux sum
    localparam int PW = SW + KW;  // scaled flux
    localparam int XW = PW + 1;   // source minus scaled flux
    localparam logic signed [PW-1:0] RND_BIAS = PW'(1) <<< (FRAC - 1);

    logic signed [LW-1:0] tv   [NTAPS];
    logic signed [LW-1:0] lap  [NLAPS];
    logic signed [SW-1:0] lapx [NLAPS];
    logic signed [SW-1:0] fsum;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [XW-1:0] diff;
    logic [XW-DW:0]       hi_bits;
    logic                 ovf;

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        assign tv[k] = {{(LW-DW){taps[k*DW+DW-1]}}, taps[k*DW +: DW]};
    end

    for (genvar k = 0; k < NLAPS; k++) begin : g_lap
        assign lap[k]  = (tv[k] <<< 2) - tv[lap_nb(k, 0)] - tv[lap_nb(k, 1)]
                       - tv[lap_nb(k, 2)] - tv[lap_nb(k, 3)];
        assign lapx[k] = SW'(lap[k]);
    end

    always_comb begin
        fsum    = lapx[1] + lapx[2] + lapx[3] + lapx[4] - (lapx[0] <<< 2);
        prod    = PW'(fsum) * PW'(coef);
        scaled  = (prod + RND_BIAS) >>> FRAC;
        diff    = XW'(tv[0]) - XW'(scaled);
        hi_bits = diff[XW-1:DW-1];
        ovf     = !((&hi_bits) || (~|hi_bits));
        if (ovf) begin
            result = {diff[XW-1], {(DW-1){~diff[XW-1]}}};
        end else begin
            result = diff[DW-1:0];
        end
    end

endmodule

// File: rtl/hdiff_stencil_top.sv
module hdiff_stencil_top
    import hdiff_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int COLS  = 8,
    parameter int ROWS  = 7,
    parameter int DW    = 16,
    parameter int KW    = 16,
    parameter int FRAC  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_en,
    input  logic [idx_w(DEPTH)-1:0] fill_plane,
    input  logic [idx_w(COLS)-1:0]  fill_col,
    input  logic [idx_w(ROWS)-1:0]  fill_row,
    input  logic [DW-1:0]           fill_data,
    input  logic                    coef_we,
    input  logic [KW-1:0]           coef_in,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [DW-1:0]           out_data,
    output logic                    out_last
);

    hd_state_t state_q;
    hd_state_t state_d;

    logic [idx_w(DEPTH)-1:0] d_idx;
    logic [idx_w(COLS)-1:0]  c_idx;
    logic [idx_w(ROWS)-1:0]  r_idx;
    logic                    at_end;
    logic [NTAPS*DW-1:0]     taps;
    logic [DW-1:0]           result;
    logic [KW-1:0]           coef_reg;
    logic [KW-1:0]           coef_run;
    logic                    accept_start;
    logic                    load;
    logic                    handoff;
    logic                    store_we;

    always_comb begin
        accept_start = (state_q == ST_IDLE) && start;
        load         = (state_q == ST_RUN) && (!out_valid || out_ready);
        handoff      = out_valid && out_ready;
        store_we     = fill_en && (state_q == ST_IDLE);
    end

    hdiff_plane_store #(
        .DEPTH(DEPTH), .COLS(COLS), .ROWS(ROWS), .DW(DW)
    ) u_store (
        .clk      (clk),
        .wr_en    (store_we),
        .wr_plane (fill_plane),
        .wr_col   (fill_col),
        .wr_row   (fill_row),
        .wr_data  (fill_data),
        .rd_plane (d_idx),
        .rd_col   (c_idx),
        .rd_row   (r_idx),
        .taps     (taps)
    );

    hdiff_scan #(
        .DEPTH(DEPTH), .COLS(COLS), .ROWS(ROWS)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept_start),
        .advance (load),
        .d_idx   (d_idx),
        .c_idx   (c_idx),
        .r_idx   (r_idx),
        .at_end  (at_end)
    );

    hdiff_diff_core #(
        .DW(DW), .KW(KW), .FRAC(FRAC)
    ) u_core (
        .taps   (taps),
        .coef   (coef_run),
        .result (result)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)            state_d = ST_RUN;
            ST_RUN:    if (load && at_end)   state_d = ST_DRAIN;
            ST_DRAIN:  if (handoff)          state_d = ST_FINISH;
            ST_FINISH:                       state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_FINISH);
    end

    // coefficient register and per-run copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_reg <= '0;
            coef_run <= '0;
        end else begin
            if (coef_we) begin
                coef_reg <= coef_in;
            end
            if (accept_start) begin
                coef_run <= coef_we ? coef_in : coef_reg;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= result;
            out_last  <= at_end;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/hdiff_stencil_chk.sv
module hdiff_stencil_chk #(
    parameter int DEPTH = 2,
    parameter int COLS  = 8,
    parameter int ROWS  = 7,
    parameter int DW    = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_last
);

    localparam int TOTAL = DEPTH * (COLS - 4) * (ROWS - 4);
    localparam int CNTW  = $clog2(TOTAL + 1);

    logic            hs;
    logic [CNTW-1:0] cnt;

    assign hs = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (done) begin
            cnt <= '0;
        end else if (hs) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready && out_last));

    a_r7_last_position: assert property (@(posedge clk) disable iff (!rst_n)
        hs && out_last |-> cnt == CNTW'(TOTAL - 1));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hs && !out_last |-> cnt < CNTW'(TOTAL - 1));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);

endmodule

bind hdiff_stencil_top hdiff_stencil_chk #(
    .DEPTH(DEPTH), .COLS(COLS), .ROWS(ROWS), .DW(DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/test_hdiff_stencil_top.sv
module test_hdiff_stencil_top;
    import hdiff_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 2;
    localparam int COLS  = 8;
    localparam int ROWS  = 7;
    localparam int DW    = 16;
    localparam int KW    = 16;
    localparam int FRAC  = 8;
    localparam int NPL   = (COLS - 4) * (ROWS - 4);
    localparam int TOTAL = NPL * DEPTH;

    // stimulus vectors: pattern kind and coefficient; expected values come from the model below
    localparam int NVEC = 6;
    localparam int VEC_PAT  [NVEC] = '{0, 1, 2, 2, 3, 2};
    localparam int VEC_COEF [NVEC] = '{256, -300, 128, -77, 256, 3};

    logic clk;
    logic rst_n;
    logic fill_en;
    logic [idx_w(DEPTH)-1:0] fill_plane;
    logic [idx_w(COLS)-1:0]  fill_col;
    logic [idx_w(ROWS)-1:0]  fill_row;
    logic [DW-1:0] fill_data;
    logic coef_we;
    logic [KW-1:0] coef_in;
    logic start;
    logic busy;
    logic done;
    logic out_valid;
    logic out_ready;
    logic [DW-1:0] out_data;
    logic out_last;

    int checks;
    int errors;
    int src_m [DEPTH][COLS][ROWS];

    hdiff_stencil_top #(
        .DEPTH(DEPTH), .COLS(COLS), .ROWS(ROWS), .DW(DW), .KW(KW), .FRAC(FRAC)
    ) i_hdiff_stencil_top (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_plane(fill_plane),
        .fill_col(fill_col), .fill_row(fill_row), .fill_data(fill_data),
        .coef_we(coef_we), .coef_in(coef_in), .start(start), .busy(busy),
        .done(done), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int pat_val(input int p, input int d, input int c, input int r);
        case (p)
            0:       return 100;
            1:       return 3 * c + 5 * r - 7 * d;
            2:       return ((d * 37 + c * 11 + r * 7) * (c + 3) * (r + 5)) % 200 - 100;
            default: return ((c + r) % 2 == 0) ? 30000 : -30000;
        endcase
    endfunction

    function automatic longint lap(input int d, input int c, input int r);
        return 4 * src_m[d][c][r] - src_m[d][c-1][r] - src_m[d][c+1][r]
               - src_m[d][c][r-1] - src_m[d][c][r+1];
    endfunction

    function automatic int model(input int d, input int c, input int r, input int k);
        longint f;
        longint q;
        longint v;
        f = (lap(d, c+1, r) - lap(d, c, r)) - (lap(d, c, r) - lap(d, c-1, r))
          + (lap(d, c, r+1) - lap(d, c, r)) - (lap(d, c, r) - lap(d, c, r-1));
        q = (longint'(k) * f + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
        v = longint'(src_m[d][c][r]) - q;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return int'(v);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill_pattern(input int p);
        for (int d = 0; d < DEPTH; d++) begin
            for (int c = 0; c < COLS; c++) begin
                for (int r = 0; r < ROWS; r++) begin
                    @(negedge clk);
                    fill_en    = 1'b1;
                    fill_plane = idx_w(DEPTH)'(d);
                    fill_col   = idx_w(COLS)'(c);
                    fill_row   = idx_w(ROWS)'(r);
                    fill_data  = DW'(pat_val(p, d, c, r));
                    src_m[d][c][r] = pat_val(p, d, c, r);
                end
            end
        end
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic write_coef(input int v);
        @(negedge clk);
        coef_we = 1'b1;
        coef_in = KW'(v);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    // one run; ready_mode 0 keeps ready high, 1 stalls one cycle in three
    task automatic run_check(input int coef_exp, input int ready_mode, input bit start_coef,
                             input int start_coef_val, input bit disturb, input string req);
        int k = 0;
        int dn = 0;
        int cyc = 0;
        int first = -1;
        int lastc = -1;
        bit stalled = 1'b0;
        logic [DW-1:0] held = '0;
        @(negedge clk);
        start   = 1'b1;
        coef_we = start_coef;
        coef_in = KW'(start_coef_val);
        @(negedge clk);
        start   = 1'b0;
        coef_we = 1'b0;
        check(busy == 1'b1, "R9", "busy after start", longint'(busy), 1);
        while (dn == 0 && cyc < 2000) begin
            if (disturb && cyc == 3) begin
                fill_en = 1'b1; fill_plane = '0; fill_col = 3'd3; fill_row = 3'd3;
                fill_data = DW'(12345);
                coef_we = 1'b1; coef_in = KW'(777);
                start = 1'b1;
            end else if (disturb && cyc == 4) begin
                fill_en = 1'b0; coef_we = 1'b0; start = 1'b0;
            end
            out_ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 != 1);
            if (stalled) begin
                check(out_valid && out_data == held, "R8", "data held under stall",
                      longint'(out_data), longint'(held));
            end
            stalled = out_valid && !out_ready;
            held    = out_data;
            if (out_valid && out_ready) begin
                int d = k / NPL;
                int c = 2 + (k % NPL) / (ROWS - 4);
                int r = 2 + (k % NPL) % (ROWS - 4);
                int e = model(d, c, r, coef_exp);
                check($signed(out_data) == e, req, "sample value",
                      longint'($signed(out_data)), longint'(e));
                check(out_last == (k == TOTAL - 1), "R7", "last flag",
                      longint'(out_last), longint'(k == TOTAL - 1));
                if (first < 0) first = cyc;
                lastc = cyc;
                k++;
            end
            if (done) begin
                check(k == TOTAL, "R9", "done after final sample", k, TOTAL);
                dn = 1;
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        check(k == TOTAL, "R3", "sample count", k, TOTAL);
        check(dn == 1, "R9", "done seen", dn, 1);
        check(done == 1'b0 && busy == 1'b0, "R9", "done one cycle, idle after",
              longint'({done, busy}), 0);
        if (ready_mode == 0) begin
            check(lastc - first == TOTAL - 1, "R8", "back-to-back samples",
                  lastc - first, TOTAL - 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        checks = 0; errors = 0;
        rst_n = 1'b0; fill_en = 1'b0; fill_plane = '0; fill_col = '0; fill_row = '0;
        fill_data = '0; coef_we = 1'b0; coef_in = '0; start = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && out_valid == 1'b0, "R11", "reset outputs",
              longint'({busy, done, out_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            string req;
            req = (VEC_PAT[v] == 3) ? "R6" : ((VEC_COEF[v] == -77 || VEC_COEF[v] == 3) ? "R5" : "R4");
            fill_pattern(VEC_PAT[v]);
            write_coef(VEC_COEF[v]);
            run_check(VEC_COEF[v], v % 2, 1'b0, 0, 1'b0, req);
        end

        // coefficient written in the start cycle; fill, coefficient and start during the run
        write_coef(50);
        run_check(90, 0, 1'b1, 90, 1'b1, "R2");
        // later run: mid-run coefficient now active, tile untouched by the busy-time fill
        run_check(777, 1, 1'b0, 0, 1'b0, "R1");
        // R10 covered by the repeated start inside the R2 run keeping count and order

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule